// File: doc/BRIEF.md
# Dual-Length Serial Configuration Interface

This block is the serial slave that configures a sixteen-channel output driver. A host drives a data line and a shift strobe. A select input decides which of two configuration words the shared shift register gathers. With select low, the register is 16 bits long and loads an on/off register, one bit per channel. With select high, it is 112 bits long and loads a dot-correction register that holds a seven-bit brightness trim for each channel. A latch strobe commits the gathered word. The latch strobe acts on its rising edge for the on/off word. For the trim word it acts as a level: the register follows the shift register while the strobe is high.

The shift register also reads back status. On the rising latch strobe in on/off mode, the block captures sixteen open-load flags that come from outside. While the strobe stays high, it forces those flags into the shift register. After the strobe falls, each shift strobe walks the flags out of the serial output, highest channel first. The serial output is always the last stage of the active length, so devices can be chained output to input. The shift and latch strobes are treated as levels sampled by the fast system clock. A rising edge is recognised when the sampled level is high and was low at the previous sample.

Top module: `led_serial_cfg`

## Requirements
- R1: While `rst` is high, the on/off register, the trim register and `sout_o` are all zero from the next clock on.
- R2: With `mode_i` low, a rising `xlat_i` copies the 16-bit shift register into `onoff_o`. The first bit shifted in lands in bit 15, which is channel 15.
- R3: With `mode_i` low and `xlat_i` low, `sout_o` repeats the `sin_i` value taken 16 rising `sclk_i` edges earlier.
- R4: With `mode_i` high, the 112-bit frame carries channel 15 first, and each seven-bit value is sent MSB first. Channel n appears on `dotcorr_o[7n+6:7n]` once `xlat_i` is high.
- R5: With `mode_i` high, `dotcorr_o` follows the shift register while `xlat_i` is high. It keeps its value while `xlat_i` is low, whatever is shifted in.
- R6: `onoff_o` changes only on a rising `xlat_i` with `mode_i` low. Shifting, and latch strobes with `mode_i` high, leave it unchanged.
- R7: With `mode_i` low and `xlat_i` high, the low 16 shift stages hold the captured open-load flags. `sclk_i` edges are ignored, and `sout_o` shows the channel 15 flag.
- R8: After `xlat_i` falls, `sout_o` still shows the channel 15 flag. Each following rising `sclk_i` moves it to the next lower channel: 14, then 13, down to 0.
- R9: The open-load flags are sampled only on the rising `xlat_i` with `mode_i` low. Later changes on `open_flags_i` do not alter the flags that are read back.
- R10: Changing `mode_i` only changes which stage drives `sout_o` (stage 15 when low, stage 111 when high). Stages above 15 are neither cleared nor moved by shifting while `mode_i` is low.
- R11: With `mode_i` high and `xlat_i` low, `sout_o` repeats the `sin_i` value taken 112 rising `sclk_i` edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every strobe |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Shift strobe, acts on its rising edge |
| sin_i | input | 1 | Serial data in |
| xlat_i | input | 1 | Latch strobe |
| mode_i | input | 1 | Length select: 0 on/off word, 1 trim word |
| open_flags_i | input | 16 | Open-load flags, bit n for channel n |
| sout_o | output | 1 | Serial data out, last active stage |
| onoff_o | output | 16 | On/off register, bit n for channel n |
| dotcorr_o | output | 112 | Trim register, channel n at bits 7n+6:7n |

## Verification
Three things can land in the same system-clock cycle: a shift strobe edge, the rising latch strobe that commits the on/off word, and the forced load of the flags. The bench raises `sclk_i` and `xlat_i` at the same moment. It then expects `onoff_o` to hold the word as it stood before that edge and `sout_o` to show the channel 15 flag, not the shifted bit. It also pulses `sclk_i` during the high strobe and changes the flag inputs. The flag sequence read back afterwards must match the flags captured at the rising edge.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    parameter int unsigned DEF_CHANNELS = 16;
    parameter int unsigned DEF_DC_WIDTH = 7;

    typedef enum logic {
        LEN_ONOFF = 1'b0,
        LEN_DOT   = 1'b1
    } len_sel_e;

    typedef struct packed {
        logic sclk_rise;
        logic xlat_rise;
        logic xlat_level;
    } strobes_t;

    function automatic int unsigned frame_bits(input int unsigned ch, input int unsigned w);
        return ch * w;
    endfunction

endpackage

// File: rtl/lsc_edge.sv
module lsc_edge #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] lvl_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) lvl_q[i] <= 1'b0;
            else     lvl_q[i] <= lvl_i[i];
        end
        assign rise_o[i] = lvl_i[i] & ~lvl_q[i];
    end

endmodule

// File: rtl/lsc_shifter.sv
module lsc_shifter
    import lsc_pkg::*;
#(
    parameter int unsigned CHANNELS = DEF_CHANNELS,
    parameter int unsigned TOT      = frame_bits(DEF_CHANNELS, DEF_DC_WIDTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  len_sel_e            len_i,
    input  logic                shift_en_i,
    input  logic                force_i,
    input  logic [CHANNELS-1:0] force_val_i,
    input  logic                sin_i,
    output logic [TOT-1:0]      shift_q,
    output logic                sout_o
);

    logic [TOT-1:0] shift_d;

    always_comb begin
        shift_d = shift_q;
        if (force_i) begin
            shift_d[CHANNELS-1:0] = force_val_i;
        end else if (shift_en_i) begin
            if (len_i == LEN_DOT) shift_d = {shift_q[TOT-2:0], sin_i};
            else                  shift_d[CHANNELS-1:0] = {shift_q[CHANNELS-2:0], sin_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= shift_d;
    end

    assign sout_o = (len_i == LEN_DOT) ? shift_q[TOT-1] : shift_q[CHANNELS-1];

endmodule

// File: rtl/lsc_latches.sv
module lsc_latches
    import lsc_pkg::*;
#(
    parameter int unsigned CHANNELS = DEF_CHANNELS,
    parameter int unsigned TOT      = frame_bits(DEF_CHANNELS, DEF_DC_WIDTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  strobes_t            stb_i,
    input  len_sel_e            len_i,
    input  logic [TOT-1:0]      shift_i,
    input  logic [CHANNELS-1:0] flags_i,
    output logic [CHANNELS-1:0] onoff_o,
    output logic [TOT-1:0]      dotcorr_o,
    output logic [CHANNELS-1:0] flag_q
);

    logic commit_onoff;
    logic follow_dot;

    assign commit_onoff = stb_i.xlat_rise && (len_i == LEN_ONOFF);
    assign follow_dot   = stb_i.xlat_level && (len_i == LEN_DOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            onoff_o <= '0;
            flag_q  <= '0;
        end else if (commit_onoff) begin
            onoff_o <= shift_i[CHANNELS-1:0];
            flag_q  <= flags_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             dotcorr_o <= '0;
        else if (follow_dot) dotcorr_o <= shift_i;
    end

endmodule

// File: rtl/led_serial_cfg.sv
module led_serial_cfg
    import lsc_pkg::*;
#(
    parameter int unsigned CHANNELS = DEF_CHANNELS,
    parameter int unsigned DC_WIDTH = DEF_DC_WIDTH
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              sclk_i,
    input  logic                              sin_i,
    input  logic                              xlat_i,
    input  logic                              mode_i,
    input  logic [CHANNELS-1:0]               open_flags_i,
    output logic                              sout_o,
    output logic [CHANNELS-1:0]               onoff_o,
    output logic [CHANNELS*DC_WIDTH-1:0]      dotcorr_o
);

    localparam int unsigned TOT = frame_bits(CHANNELS, DC_WIDTH);

    logic [1:0]          rise;
    strobes_t            stb;
    len_sel_e            len;
    logic                force_load;
    logic [CHANNELS-1:0] flag_q;
    logic [CHANNELS-1:0] force_val;
    logic [TOT-1:0]      shift_q;

    lsc_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  ({xlat_i, sclk_i}),
        .rise_o (rise)
    );

    assign stb        = '{sclk_rise: rise[0], xlat_rise: rise[1], xlat_level: xlat_i};
    assign len        = len_sel_e'(mode_i);
    assign force_load = (len == LEN_ONOFF) && stb.xlat_level;
    assign force_val  = stb.xlat_rise ? open_flags_i : flag_q;

    lsc_shifter #(.CHANNELS(CHANNELS), .TOT(TOT)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .len_i       (len),
        .shift_en_i  (stb.sclk_rise),
        .force_i     (force_load),
        .force_val_i (force_val),
        .sin_i       (sin_i),
        .shift_q     (shift_q),
        .sout_o      (sout_o)
    );

    lsc_latches #(.CHANNELS(CHANNELS), .TOT(TOT)) u_lat (
        .clk       (clk),
        .rst       (rst),
        .stb_i     (stb),
        .len_i     (len),
        .shift_i   (shift_q),
        .flags_i   (open_flags_i),
        .onoff_o   (onoff_o),
        .dotcorr_o (dotcorr_o),
        .flag_q    (flag_q)
    );

endmodule

// File: rtl/led_serial_cfg_chk.sv
module led_serial_cfg_chk #(
    parameter int unsigned CHANNELS = 16,
    parameter int unsigned DC_WIDTH = 7
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         xlat_i,
    input logic                         mode_i,
    input logic                         sout_o,
    input logic [CHANNELS-1:0]          onoff_o,
    input logic [CHANNELS*DC_WIDTH-1:0] dotcorr_o,
    input logic [CHANNELS*DC_WIDTH-1:0] shift_q
);

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (onoff_o == '0 && dotcorr_o == '0));

    // R6
    p_onoff_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(xlat_i && !$past(xlat_i) && !mode_i) |=> $stable(onoff_o));

    // R5
    p_dc_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!xlat_i || !mode_i) |=> $stable(dotcorr_o));

    // R4
    p_dc_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (xlat_i && mode_i) |=> (dotcorr_o == $past(shift_q)));

    // R7
    p_flag_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (!mode_i && !$past(mode_i) && !$past(mode_i, 2) && $past(xlat_i) && $past(xlat_i, 2))
        |-> $stable(sout_o));

endmodule

bind led_serial_cfg led_serial_cfg_chk #(.CHANNELS(CHANNELS), .DC_WIDTH(DC_WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .xlat_i    (xlat_i),
    .mode_i    (mode_i),
    .sout_o    (sout_o),
    .onoff_o   (onoff_o),
    .dotcorr_o (dotcorr_o),
    .shift_q   (shift_q)
);

// File: tb/led_serial_cfg_test.sv
`timescale 1ns/1ps
module led_serial_cfg_test;

    localparam int CH  = 16;
    localparam int DCW = 7;
    localparam int TOT = CH * DCW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sclk_i = 1'b0;
    logic           sin_i = 1'b0;
    logic           xlat_i = 1'b0;
    logic           mode_i = 1'b0;
    logic [CH-1:0]  open_flags_i = '0;
    logic           sout_o;
    logic [CH-1:0]  onoff_o;
    logic [TOT-1:0] dotcorr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    led_serial_cfg uut (
        .clk          (clk),
        .rst          (rst),
        .sclk_i       (sclk_i),
        .sin_i        (sin_i),
        .xlat_i       (xlat_i),
        .mode_i       (mode_i),
        .open_flags_i (open_flags_i),
        .sout_o       (sout_o),
        .onoff_o      (onoff_o),
        .dotcorr_o    (dotcorr_o)
    );

    always #5 clk = ~clk;

    // {on/off word, open-load flags}
    localparam logic [31:0] VEC [4] = '{
        32'hA5C3_8001,
        32'h0001_FFFE,
        32'hFFFF_0000,
        32'h6B2D_93C5
    };

    task automatic chk(input string tag, input logic [TOT-1:0] act, input logic [TOT-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sin_i  = b;
        sclk_i = 1'b1;
        step();
        sclk_i = 1'b0;
        step();
    endtask

    function automatic logic [TOT-1:0] make_frame(input int seed);
        logic [TOT-1:0] f;
        f = '0;
        for (int n = 0; n < CH; n++) f[n*DCW +: DCW] = 7'((n * seed + 3) & 7'h7F);
        return f;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [CH-1:0]  word, flags, wa;
        logic [TOT-1:0] f1, f2, s;

        repeat (3) step();
        chk("R1 onoff reset", TOT'(onoff_o), '0);
        chk("R1 dotcorr reset", dotcorr_o, '0);
        chk("R1 sout reset", TOT'(sout_o), '0);
        rst = 1'b0;
        step();

        // table walk: on/off writes, same-cycle strobes, flag readback
        for (int v = 0; v < 4; v++) begin
            word  = VEC[v][31:16];
            flags = VEC[v][15:0];
            mode_i = 1'b0;
            for (int b = CH - 1; b >= 0; b--) pulse(word[b]);
            open_flags_i = flags;
            sin_i  = 1'b1;
            xlat_i = 1'b1;
            sclk_i = 1'b1;
            step();
            sclk_i = 1'b0;
            chk("R2 onoff commit", TOT'(onoff_o), TOT'(word));
            chk("R7 sout flag15 at commit", TOT'(sout_o), TOT'(flags[CH-1]));
            step();
            pulse(1'b1);
            chk("R7 sclk ignored while forced", TOT'(sout_o), TOT'(flags[CH-1]));
            open_flags_i = ~flags;
            step();
            chk("R9 flags change ignored", TOT'(sout_o), TOT'(flags[CH-1]));
            xlat_i = 1'b0;
            step();
            chk("R8 flag15 after fall", TOT'(sout_o), TOT'(flags[CH-1]));
            for (int k = CH - 2; k >= 0; k--) begin
                pulse(1'b0);
                chk("R8 flag readback", TOT'(sout_o), TOT'(flags[k]));
            end
            chk("R6 onoff held over shifting", TOT'(onoff_o), TOT'(word));
        end

        // R3: 16-stage delay in on/off mode
        wa = 16'hC35A;
        for (int b = CH - 1; b >= 0; b--) pulse(wa[b]);
        for (int k = CH - 1; k >= 0; k--) begin
            chk("R3 sout delay 16", TOT'(sout_o), TOT'(wa[k]));
            pulse(k[0]);
        end

        // R4: trim frame write
        mode_i = 1'b1;
        step();
        f1 = make_frame(9);
        for (int b = TOT - 1; b >= 0; b--) pulse(f1[b]);
        xlat_i = 1'b1;
        step();
        chk("R4 dotcorr frame", dotcorr_o, f1);
        chk("R4 channel 15 value", TOT'(dotcorr_o[15*DCW +: DCW]), TOT'(7'((15 * 9 + 3) & 7'h7F)));
        chk("R6 onoff untouched by trim strobe", TOT'(onoff_o), TOT'(VEC[3][31:16]));
        xlat_i = 1'b0;
        step();

        // R11 and R5 hold: stream new frame with strobe low
        f2 = make_frame(23);
        for (int b = TOT - 1; b >= 0; b--) begin
            chk("R11 sout delay 112", TOT'(sout_o), TOT'(f1[b]));
            pulse(f2[b]);
        end
        chk("R5 dotcorr held while low", dotcorr_o, f1);
        xlat_i = 1'b1;
        step();
        chk("R5 dotcorr follows while high", dotcorr_o, f2);
        pulse(1'b1);
        s = {f2[TOT-2:0], 1'b1};
        chk("R5 dotcorr transparent", dotcorr_o, s);
        xlat_i = 1'b0;
        step();

        // R10: mode switch keeps contents
        mode_i = 1'b0;
        step();
        chk("R10 low tap after switch", TOT'(sout_o), TOT'(s[CH-1]));
        wa = 16'h9E17;
        for (int b = CH - 1; b >= 0; b--) pulse(wa[b]);
        mode_i = 1'b1;
        step();
        chk("R10 upper stages kept", TOT'(sout_o), TOT'(s[TOT-1]));
        for (int k = 0; k < TOT - CH; k++) pulse(1'b0);
        chk("R10 low stages carried up", TOT'(sout_o), TOT'(wa[CH-1]));
        chk("R5 dotcorr held after mode moves", dotcorr_o, s);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule